// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised pin count that is a multiple of 32. Software uses a simple 32-bit register bus with a write strobe, a byte address and read data. Through this bus it chooses which pins drive, and it raises or lowers outputs with write-one set and clear words. It also arms per-pin rising or falling edge capture and clears captured edges by writing ones. A 2-bit alternate-function code per pin is stored for use by surrounding pad logic. Pin inputs cross into the clock domain through two flops, and one further sample gives the previous value used for edge comparison.

The register space is grouped by feature. Each feature is an array of `NPINS/32` words, and the arrays follow one another. The byte address of a word is `(feature * NPINS/32 + bank) * 4`, where bank is `pin / 32`, and the feature codes are 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status and 7 alternate function. The alternate-function array is twice as long as the others, because it packs 16 pins per word. A single interrupt line reports whether any edge-status bit is pending.

The block has no state machine. Its behaviour is a register file with a per-bank edge datapath, and there are no named states or transitions.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A word at byte address `(f * NPINS/32 + b) * 4` belongs to feature f and bank b. The alternate-function words start at feature index 7 and run for `2 * NPINS/32` words. Any word address beyond them reads as zero, and a write to it changes no register or output.
- R2: The level word of bank b returns the pin inputs `gpio_i[32b+31:32b]` after two clock edges of synchronisation. A change applied before edge k is not visible after edge k, and it is visible after edge k+1.
- R3: A direction bit of 1 makes the pin an output (`gpio_oe_o` high), and 0 makes it an input. The direction word reads back what was written.
- R4: Writing 1 to a bit of a set word drives that output high, and writing 1 to a bit of a clear word drives it low. Zero bits leave the output unchanged. Set and clear words read as zero.
- R5: A pin whose rising enable bit is 1 sets its edge-status bit when its synchronised level goes from 0 to 1.
- R6: A pin whose falling enable bit is 1 sets its edge-status bit when its synchronised level goes from 1 to 0. A transition in a direction that is not enabled sets nothing.
- R7: An edge-status bit stays set until a 1 is written to it. Writing 0 has no effect, and writing all ones clears every bit of that word.
- R8: When an edge is detected in the same cycle as a write that clears its status bit, the bit ends up set. Other bits cleared by that write end up clear.
- R9: `irq_o` is high whenever any edge-status bit is set, and it stays high until software has cleared every set bit.
- R10: Pin p's alternate-function code sits in word `p/16` of the alternate-function array, at bits `[(p%16)*2+1 : (p%16)*2]`. Each word stores and reads back all 32 bits.
- R11: After reset, direction, outputs, edge enables, edge status and alternate-function codes are all zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | ADDR_W | Byte address; the two low bits are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word (combinational) |
| gpio_i | input | NPINS | Pin input levels |
| gpio_o | output | NPINS | Output levels driven to the pins |
| gpio_oe_o | output | NPINS | Per-pin output enable |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The hardest case is a write that clears the edge status landing on the same edge as a new detection. A design that lets the clear win drops that edge, and the status word reads zero where one bit should remain. The bench also checks the two-edge latency of the level word, so a missing or extra synchroniser stage shows up at the intermediate sample. Write-one semantics get their own checks: a zero write that cleared status or outputs, or a set or clear word that read back its value, shows as a wrong word. Out-of-range writes must leave the direction, output, status and alternate-function state untouched. A decoder that wraps the address would corrupt one of those words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W        = 32;
    localparam int ALTF_BITS     = 2;
    localparam int ALTF_PER_WORD = WORD_W / ALTF_BITS;
    localparam int N_FEAT_PLAIN  = 7;

    typedef enum logic [2:0] {
        FEAT_LEVEL = 3'd0,
        FEAT_DIR   = 3'd1,
        FEAT_SET   = 3'd2,
        FEAT_CLR   = 3'd3,
        FEAT_RISE  = 3'd4,
        FEAT_FALL  = 3'd5,
        FEAT_STAT  = 3'd6,
        FEAT_ALTF  = 3'd7
    } feat_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int ADDR_W = 8,
    localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int AIDX_W = $clog2(2 * NBANK)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              reg_hit_o,
    output feat_e             feat_o,
    output logic [BIDX_W-1:0] bank_o,
    output logic              altf_hit_o,
    output logic [AIDX_W-1:0] altf_idx_o
);

    localparam int PLAIN_WORDS = N_FEAT_PLAIN * NBANK;
    localparam int ALL_WORDS   = PLAIN_WORDS + 2 * NBANK;

    logic [1:0]  addr_unused;
    int unsigned word;

    assign addr_unused = addr_i[1:0];

    always_comb begin
        word       = 32'(addr_i[ADDR_W-1:2]);
        reg_hit_o  = 1'b0;
        altf_hit_o = 1'b0;
        feat_o     = FEAT_LEVEL;
        bank_o     = '0;
        altf_idx_o = '0;
        if (word < 32'(PLAIN_WORDS)) begin
            reg_hit_o = 1'b1;
            feat_o    = feat_e'(3'(word / 32'(NBANK)));
            bank_o    = BIDX_W'(word % 32'(NBANK));
        end else if (word < 32'(ALL_WORDS)) begin
            altf_hit_o = 1'b1;
            altf_idx_o = AIDX_W'(word - 32'(PLAIN_WORDS));
        end
    end

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
    import gpio_bank_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              wr_dir_i,
    input  logic              wr_set_i,
    input  logic              wr_clr_i,
    input  logic              wr_rise_i,
    input  logic              wr_fall_i,
    input  logic              wr_stat_i,
    input  logic [WORD_W-1:0] sync_i,
    input  logic [WORD_W-1:0] prev_i,
    output logic [WORD_W-1:0] dir_o,
    output logic [WORD_W-1:0] out_o,
    output logic [WORD_W-1:0] rise_o,
    output logic [WORD_W-1:0] fall_o,
    output logic [WORD_W-1:0] stat_o
);

    logic [WORD_W-1:0] dir_q, out_q, rise_q, fall_q, stat_q;
    logic [WORD_W-1:0] detect, clr_mask, out_next;

    // Edge found this cycle; OR-ed in after the clear so it wins over it
    assign detect   = (rise_q & sync_i & ~prev_i) | (fall_q & ~sync_i & prev_i);
    assign clr_mask = wr_stat_i ? wdata_i : '0;

    always_comb begin
        out_next = out_q;
        if (wr_set_i) out_next = out_next | wdata_i;
        if (wr_clr_i) out_next = out_next & ~wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_dir_i)  dir_q  <= wdata_i;
            if (wr_rise_i) rise_q <= wdata_i;
            if (wr_fall_i) fall_q <= wdata_i;
            out_q  <= out_next;
            stat_q <= (stat_q & ~clr_mask) | detect;
        end
    end

    assign dir_o  = dir_q;
    assign out_o  = out_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;
    assign stat_o = stat_q;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [NPINS-1:0]  gpio_i,
    output logic [NPINS-1:0]  gpio_o,
    output logic [NPINS-1:0]  gpio_oe_o,
    output logic              irq_o
);

    localparam int NBANK  = NPINS / WORD_W;
    localparam int NALTF  = 2 * NBANK;
    localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int AIDX_W = $clog2(NALTF);

    logic              reg_hit, altf_hit;
    feat_e             feat;
    logic [BIDX_W-1:0] bank;
    logic [AIDX_W-1:0] altf_idx;

    logic [NPINS-1:0]  sync_all, prev_all;
    logic [NPINS-1:0]  stat_all, rise_all, fall_all;

    logic [WORD_W-1:0] dir_w  [NBANK];
    logic [WORD_W-1:0] rise_w [NBANK];
    logic [WORD_W-1:0] fall_w [NBANK];
    logic [WORD_W-1:0] stat_w [NBANK];
    logic [WORD_W-1:0] lvl_w  [NBANK];
    logic [WORD_W-1:0] altf_q [NALTF];

    gpio_in_sync #(.W(NPINS)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (gpio_i),
        .sync_o (sync_all),
        .prev_o (prev_all)
    );

    gpio_addr_decode #(.NBANK(NBANK), .ADDR_W(ADDR_W)) i_dec (
        .addr_i     (addr_i),
        .reg_hit_o  (reg_hit),
        .feat_o     (feat),
        .bank_o     (bank),
        .altf_hit_o (altf_hit),
        .altf_idx_o (altf_idx)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en_i && reg_hit && (bank == BIDX_W'(b));

        gpio_bank_slice i_slice (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wdata_i   (wdata_i),
            .wr_dir_i  (bank_wr && feat == FEAT_DIR),
            .wr_set_i  (bank_wr && feat == FEAT_SET),
            .wr_clr_i  (bank_wr && feat == FEAT_CLR),
            .wr_rise_i (bank_wr && feat == FEAT_RISE),
            .wr_fall_i (bank_wr && feat == FEAT_FALL),
            .wr_stat_i (bank_wr && feat == FEAT_STAT),
            .sync_i    (sync_all[b*WORD_W +: WORD_W]),
            .prev_i    (prev_all[b*WORD_W +: WORD_W]),
            .dir_o     (dir_w[b]),
            .out_o     (gpio_o[b*WORD_W +: WORD_W]),
            .rise_o    (rise_w[b]),
            .fall_o    (fall_w[b]),
            .stat_o    (stat_w[b])
        );

        assign lvl_w[b]                       = sync_all[b*WORD_W +: WORD_W];
        assign gpio_oe_o[b*WORD_W +: WORD_W]  = dir_w[b];
        assign stat_all[b*WORD_W +: WORD_W]   = stat_w[b];
        assign rise_all[b*WORD_W +: WORD_W]   = rise_w[b];
        assign fall_all[b*WORD_W +: WORD_W]   = fall_w[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NALTF; i++) altf_q[i] <= '0;
        end else if (wr_en_i && altf_hit) begin
            altf_q[altf_idx] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (reg_hit) begin
            unique case (feat)
                FEAT_LEVEL: rdata_o = lvl_w[bank];
                FEAT_DIR:   rdata_o = dir_w[bank];
                FEAT_RISE:  rdata_o = rise_w[bank];
                FEAT_FALL:  rdata_o = fall_w[bank];
                FEAT_STAT:  rdata_o = stat_w[bank];
                default:    rdata_o = '0;
            endcase
        end else if (altf_hit) begin
            rdata_o = altf_q[altf_idx];
        end
    end

    assign irq_o = |stat_all;

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
    parameter int NPINS = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             irq_i,
    input logic [NPINS-1:0] gpio_o_i,
    input logic [NPINS-1:0] gpio_oe_i,
    input logic [NPINS-1:0] rise_all_i,
    input logic [NPINS-1:0] fall_all_i
);

    p_dir_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(gpio_oe_i))
        else $error("p_dir_hold_r3");

    p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(gpio_o_i))
        else $error("p_out_hold_r4");

    p_unarmed_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_i && rise_all_i == '0 && fall_all_i == '0) |=> !irq_i)
        else $error("p_unarmed_quiet_r6");

    p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i && !wr_en_i) |=> irq_i)
        else $error("p_irq_sticky_r9");

endmodule

bind gpio_bank_ctrl gpio_bank_checker #(.NPINS(NPINS)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .irq_i      (irq_o),
    .gpio_o_i   (gpio_o),
    .gpio_oe_i  (gpio_oe_o),
    .rise_all_i (rise_all),
    .fall_all_i (fall_all)
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;

    localparam int NPINS  = 64;
    localparam int NBANK  = NPINS / 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NPINS-1:0]  gpio_in = '0;
    logic [NPINS-1:0]  gpio_out, gpio_oe;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_bank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_gpio_bank_ctrl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .gpio_i    (gpio_in),
        .gpio_o    (gpio_out),
        .gpio_oe_o (gpio_oe),
        .irq_o     (irq)
    );

    function automatic logic [ADDR_W-1:0] a_of(int feat, int word);
        return ADDR_W'((feat * NBANK + word) * 4);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(a_of(1, 0), v); check("R11 dir", 64'(v), 0);
        rd(a_of(4, 1), v); check("R11 rise", 64'(v), 0);
        rd(a_of(6, 0), v); check("R11 stat", 64'(v), 0);
        rd(a_of(7, 3), v); check("R11 altf", 64'(v), 0);
        check("R11 pins", {gpio_out[31:0], gpio_oe[31:0]}, 0);
        check("R11 irq", 64'(irq), 0);
    endtask

    task automatic t_direction;
        logic [31:0] v;
        wr(a_of(1, 0), 32'h0000_00F0);
        check("R3 oe bank0", 64'(gpio_oe[31:0]), 64'h0000_00F0);
        rd(a_of(1, 0), v); check("R3 dir readback", 64'(v), 64'h0000_00F0);
        wr(a_of(1, 1), 32'h8000_0001);
        check("R3 oe bank1", 64'(gpio_oe[63:32]), 64'h8000_0001);
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        wr(a_of(2, 1), 32'h0000_0011);
        check("R4 set bank1", 64'(gpio_out[63:32]), 64'h11);
        wr(a_of(2, 0), 32'h0000_00A5);
        check("R4 set bank0", 64'(gpio_out[31:0]), 64'hA5);
        wr(a_of(3, 0), 32'h0000_0005);
        check("R4 clear", 64'(gpio_out[31:0]), 64'hA0);
        wr(a_of(3, 0), 32'h0);
        check("R4 zero clear", 64'(gpio_out[31:0]), 64'hA0);
        wr(a_of(2, 0), 32'h0);
        check("R4 zero set", 64'(gpio_out[31:0]), 64'hA0);
        rd(a_of(2, 0), v); check("R4 set reads 0", 64'(v), 0);
        rd(a_of(3, 1), v); check("R4 clr reads 0", 64'(v), 0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        gpio_in = 64'h0123_4567_89AB_CDEF;
        idle(1);
        rd(a_of(0, 0), v); check("R2 one edge", 64'(v), 0);
        idle(1);
        rd(a_of(0, 0), v); check("R2 level bank0", 64'(v), 64'h89AB_CDEF);
        rd(a_of(0, 1), v); check("R2 level bank1", 64'(v), 64'h0123_4567);
        gpio_in = '0;
        idle(4);
        rd(a_of(6, 0), v); check("R6 unarmed stat", 64'(v), 0);
        check("R6 unarmed irq", 64'(irq), 0);
    endtask

    task automatic t_rise;
        logic [31:0] v;
        wr(a_of(4, 0), 32'h0000_0008);
        gpio_in[3] = 1'b1;
        idle(4);
        rd(a_of(6, 0), v); check("R5 rise stat", 64'(v), 64'h8);
        check("R9 irq on", 64'(irq), 1);
        gpio_in[3] = 1'b0;
        idle(4);
        rd(a_of(6, 0), v); check("R7 sticky", 64'(v), 64'h8);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(a_of(6, 0), 32'h0);
        rd(a_of(6, 0), v); check("R7 zero write", 64'(v), 64'h8);
        wr(a_of(6, 0), 32'h8);
        rd(a_of(6, 0), v); check("R7 w1c", 64'(v), 0);
        check("R9 irq off", 64'(irq), 0);
    endtask

    task automatic t_fall;
        logic [31:0] v;
        wr(a_of(5, 1), 32'h0000_0010);
        gpio_in[36] = 1'b1;
        idle(4);
        rd(a_of(6, 1), v); check("R6 rise ignored", 64'(v), 0);
        gpio_in[36] = 1'b0;
        idle(4);
        rd(a_of(6, 1), v); check("R6 fall stat", 64'(v), 64'h10);
        gpio_in[3] = 1'b1;
        idle(4);
        wr(a_of(6, 1), 32'h10);
        check("R9 irq held", 64'(irq), 1);
        wr(a_of(6, 0), 32'hFFFF_FFFF);
        rd(a_of(6, 0), v); check("R7 all ones", 64'(v), 0);
        check("R9 irq cleared", 64'(irq), 0);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        gpio_in[3] = 1'b0;
        idle(4);
        wr(a_of(4, 0), 32'h0000_0028);
        gpio_in[5] = 1'b1;
        idle(4);
        rd(a_of(6, 0), v); check("R5 bit5 pending", 64'(v), 64'h20);
        gpio_in[3] = 1'b1;
        idle(2);
        wr(a_of(6, 0), 32'hFFFF_FFFF);   // lands on the detecting edge
        rd(a_of(6, 0), v); check("R8 detect beats clear", 64'(v), 64'h08);
        check("R8 irq", 64'(irq), 1);
        wr(a_of(6, 0), 32'h08);
        check("R9 irq after", 64'(irq), 0);
    endtask

    task automatic t_altf;
        logic [31:0] v;
        wr(a_of(7, 1), 32'h0000_0300);
        rd(a_of(7, 1), v);
        check("R10 pin20 field", 64'(v[((20 % 16) * 2) +: 2]), 3);
        wr(a_of(7, 3), 32'hC000_0001);
        rd(a_of(7, 3), v); check("R10 word3", 64'(v), 64'hC000_0001);
        rd(a_of(7, 0), v); check("R10 word0", 64'(v), 0);
    endtask

    task automatic t_range;
        logic [31:0] v;
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h48, v); check("R1 read 0x48", 64'(v), 0);
        rd(8'hFC, v); check("R1 read 0xFC", 64'(v), 0);
        rd(a_of(1, 0), v); check("R1 dir kept", 64'(v), 64'hF0);
        rd(a_of(7, 0), v); check("R1 altf kept", 64'(v), 0);
        rd(a_of(6, 0), v); check("R1 stat kept", 64'(v), 0);
        check("R1 out kept", gpio_out, {32'h11, 32'hA0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_direction;
        t_set_clear;
        t_level;
        t_rise;
        t_w1c;
        t_fall;
        t_priority;
        t_altf;
        t_range;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule